// File: doc/BRIEF.md
# Paper-Tape Word Assembler with Read-In Loader

This block turns the line frames of an 8-channel paper-tape reader into 18-bit machine words. A read command picks one of two packing modes. The first mode reads a single frame and keeps all eight channels as the low byte of a word. The second mode reads three marked frames and packs six data channels from each into one word. A finished word lands in a reader buffer and raises a ready flag. The word can also be copied into the I/O register on its own, or it can wait until an explicit take command collects it.

The same assembler serves a start-up loader. Once started, the loader reads marked words and treats them as alternating instruction words and data words. A deposit instruction names the address where the following data word is to be written. A jump instruction ends loading and reports where execution begins. Any other opcode in an instruction position stops the loader with an error and writes nothing.

Top module: `tape_word_assembler`

## Requirements
- R1: In single-frame mode, the first strobed frame after the command completes a word. The buffer holds the frame in bits 7..0 and zeros in bits 17..8.
- R2: In three-frame mode, only frames with channel 8 (frame bit 7) punched are accepted. Each accepted frame supplies its bits 5..0. The first accepted frame fills word bits 17..12, the second fills 11..6 and the third fills 5..0.
- R3: In three-frame mode, a frame without channel 8 is skipped and does not count toward the three. Frame bit 6 never reaches the word.
- R4: The ready output rises in the cycle after an externally commanded read completes. A take pulse or a reader return pulse clears it.
- R5: A take pulse copies the buffer into the I/O register. If the command had its auto flag set, the I/O register is loaded with the new word when the read completes. Without the auto flag, the I/O register keeps its value.
- R6: If a take pulse falls in the same cycle that a non-auto read completes, the I/O register receives the previous buffer word, the buffer takes the new word, and ready stays set.
- R7: Strobes that arrive while no read is in progress are ignored. A read command given while a read is in progress is ignored.
- R8: In loader mode, the first word and every second word after it are instructions, decoded on bits 17..13 (bit 12 ignored). Opcode 01101 (deposit) with address Y in bits 11..0 causes the next word to be written to memory address Y, and loading continues.
- R9: In an instruction position, opcode 11000 (jump) ends loading and issues a one-cycle jump pulse carrying bits 11..0. No memory write is made for it.
- R10: Any other opcode in an instruction position sets the error flag and ends loading without a memory write. The next loader start clears the error flag.
- R11: Words read by the loader leave the buffer, the ready flag and the I/O register untouched. External read commands are ignored while the loader is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One-cycle pulse: a tape frame is present |
| frame_data | input | 8 | Tape channels 8..1 on bits 7..0 |
| cmd_valid | input | 1 | Start one read |
| cmd_binary | input | 1 | 1 = three-frame mode, 0 = single-frame mode |
| cmd_auto | input | 1 | Copy the finished word into the I/O register |
| buf_take | input | 1 | Move the buffer into the I/O register and clear ready |
| reader_return | input | 1 | Clear ready |
| boot_start | input | 1 | Start the read-in loader |
| reader_busy | output | 1 | A read is in progress |
| word_ready | output | 1 | The buffer holds an uncollected word |
| buffer_word | output | 18 | Reader buffer |
| io_word | output | 18 | I/O register |
| boot_active | output | 1 | Loader running |
| mem_we | output | 1 | Memory write strobe from the loader |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 18 | Memory write data |
| jump_valid | output | 1 | One-cycle pulse: loading ended by a jump |
| jump_addr | output | 12 | Start address carried by the jump |
| boot_error | output | 1 | Loading stopped on an unknown opcode |

## Verification
Two events can arrive in the same cycle: a read completing, which sets ready and fills the buffer, and a take pulse, which empties the buffer into the I/O register and clears ready. The bench starts a single-frame read while an older word sits in the buffer. It strobes the frame and then raises the take pulse in exactly the cycle that the completion reaches the buffer logic. After that cycle it expects the old word in the I/O register, the new word in the buffer, and ready still high.

// File: rtl/tape_asm_pkg.sv
package tape_asm_pkg;
    localparam int unsigned TA_FRAME_W = 8;
    localparam int unsigned TA_WORD_W  = 18;
    localparam int unsigned TA_SLICE_W = 6;
    localparam int unsigned TA_ADDR_W  = 12;
    localparam int unsigned TA_OP_W    = 5;

    typedef enum logic [1:0] {
        BOOT_IDLE  = 2'd0,
        BOOT_INSTR = 2'd1,
        BOOT_DATA  = 2'd2
    } boot_state_e;
endpackage

// File: rtl/tape_frame_packer.sv
module tape_frame_packer #(
    parameter int unsigned FRAME_W = tape_asm_pkg::TA_FRAME_W,
    parameter int unsigned WORD_W  = tape_asm_pkg::TA_WORD_W,
    parameter int unsigned SLICE_W = tape_asm_pkg::TA_SLICE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_bin,
    input  logic               start_boot,
    input  logic               strobe,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               done,
    output logic               done_boot,
    output logic [WORD_W-1:0]  word
);
    localparam int unsigned FRAMES   = WORD_W / SLICE_W;
    localparam int unsigned CNT_W    = $clog2(FRAMES + 1);
    localparam int unsigned MARK_BIT = FRAME_W - 1;

    typedef struct packed {
        logic              busy;
        logic              bin;
        logic              boot;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] acc;
        logic              done;
        logic              done_boot;
        logic [WORD_W-1:0] word;
    } pk_state_t;

    pk_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.bin  = start_bin;
                st_d.boot = start_boot;
                st_d.cnt  = '0;
                st_d.acc  = '0;
            end
        end else if (strobe) begin
            if (!st_q.bin) begin
                st_d.word      = WORD_W'(frame);
                st_d.done      = 1'b1;
                st_d.done_boot = st_q.boot;
                st_d.busy      = 1'b0;
            end else if (frame[MARK_BIT]) begin
                st_d.acc = {st_q.acc[WORD_W-SLICE_W-1:0], frame[SLICE_W-1:0]};
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == CNT_W'(FRAMES - 1)) begin
                    st_d.word      = st_d.acc;
                    st_d.done      = 1'b1;
                    st_d.done_boot = st_q.boot;
                    st_d.busy      = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign done_boot = st_q.done_boot;
    assign word      = st_q.word;
endmodule

// File: rtl/tape_buffer_ctl.sv
module tape_buffer_ctl #(
    parameter int unsigned WORD_W = tape_asm_pkg::TA_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_start,
    input  logic              start_auto,
    input  logic              take,
    input  logic              ret,
    input  logic              done,
    input  logic              done_boot,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] buf_word,
    output logic              ready,
    output logic [WORD_W-1:0] io_word
);
    typedef struct packed {
        logic              auto_xfer;
        logic              ready;
        logic [WORD_W-1:0] buf_word;
        logic [WORD_W-1:0] io_word;
    } bc_state_t;

    bc_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (ext_start) begin
            st_d.auto_xfer = start_auto;
        end
        if (take) begin
            st_d.io_word = st_q.buf_word;
        end
        if (take || ret) begin
            st_d.ready = 1'b0;
        end
        if (done && !done_boot) begin
            st_d.buf_word = word;
            st_d.ready    = 1'b1;
            if (st_q.auto_xfer) begin
                st_d.io_word = word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_word = st_q.buf_word;
    assign ready    = st_q.ready;
    assign io_word  = st_q.io_word;
endmodule

// File: rtl/tape_boot_seq.sv
module tape_boot_seq
    import tape_asm_pkg::*;
#(
    parameter int unsigned WORD_W = TA_WORD_W,
    parameter int unsigned ADDR_W = TA_ADDR_W,
    parameter int unsigned OP_W   = TA_OP_W,
    parameter logic [OP_W-1:0] OP_DEP = 5'b01101,
    parameter logic [OP_W-1:0] OP_JMP = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd_busy,
    input  logic              done,
    input  logic              done_boot,
    input  logic [WORD_W-1:0] word,
    output logic              req,
    output logic              active,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [WORD_W-1:0] wdata,
    output logic              jump,
    output logic [ADDR_W-1:0] jaddr,
    output logic              error
);
    typedef struct packed {
        boot_state_e       st;
        logic [ADDR_W-1:0] dep_addr;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic              jump;
        logic [ADDR_W-1:0] jaddr;
        logic              error;
    } bs_state_t;

    bs_state_t st_q, st_d;
    logic      got_word;
    logic [OP_W-1:0] opcode;

    assign got_word = done && done_boot;
    assign opcode   = word[WORD_W-1 -: OP_W];

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.jump = 1'b0;
        unique case (st_q.st)
            BOOT_IDLE: begin
                if (go) begin
                    st_d.st    = BOOT_INSTR;
                    st_d.error = 1'b0;
                end
            end
            BOOT_INSTR: begin
                if (got_word) begin
                    if (opcode == OP_DEP) begin
                        st_d.dep_addr = word[ADDR_W-1:0];
                        st_d.st       = BOOT_DATA;
                    end else if (opcode == OP_JMP) begin
                        st_d.jump  = 1'b1;
                        st_d.jaddr = word[ADDR_W-1:0];
                        st_d.st    = BOOT_IDLE;
                    end else begin
                        st_d.error = 1'b1;
                        st_d.st    = BOOT_IDLE;
                    end
                end
            end
            BOOT_DATA: begin
                if (got_word) begin
                    st_d.we    = 1'b1;
                    st_d.waddr = st_q.dep_addr;
                    st_d.wdata = word;
                    st_d.st    = BOOT_INSTR;
                end
            end
            default: st_d.st = BOOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.st != BOOT_IDLE);
    assign req    = active && !rd_busy && !done;
    assign we     = st_q.we;
    assign waddr  = st_q.waddr;
    assign wdata  = st_q.wdata;
    assign jump   = st_q.jump;
    assign jaddr  = st_q.jaddr;
    assign error  = st_q.error;
endmodule

// File: rtl/tape_word_assembler.sv
module tape_word_assembler
    import tape_asm_pkg::*;
#(
    parameter int unsigned FRAME_W = TA_FRAME_W,
    parameter int unsigned WORD_W  = TA_WORD_W,
    parameter int unsigned SLICE_W = TA_SLICE_W,
    parameter int unsigned ADDR_W  = TA_ADDR_W,
    parameter int unsigned OP_W    = TA_OP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_strobe,
    input  logic [FRAME_W-1:0] frame_data,
    input  logic               cmd_valid,
    input  logic               cmd_binary,
    input  logic               cmd_auto,
    input  logic               buf_take,
    input  logic               reader_return,
    input  logic               boot_start,
    output logic               reader_busy,
    output logic               word_ready,
    output logic [WORD_W-1:0]  buffer_word,
    output logic [WORD_W-1:0]  io_word,
    output logic               boot_active,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               jump_valid,
    output logic [ADDR_W-1:0]  jump_addr,
    output logic               boot_error
);
    logic              pk_done;
    logic              pk_done_boot;
    logic [WORD_W-1:0] pk_word;
    logic              boot_req;
    logic              boot_go;
    logic              ext_start;
    logic              pk_start;

    // loader launch needs an idle reader with no completion in flight
    assign boot_go   = boot_start && !boot_active && !reader_busy && !pk_done;
    assign ext_start = cmd_valid && !boot_active && !boot_go && !reader_busy;
    assign pk_start  = boot_req || ext_start;

    tape_frame_packer #(
        .FRAME_W (FRAME_W),
        .WORD_W  (WORD_W),
        .SLICE_W (SLICE_W)
    ) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (pk_start),
        .start_bin  (boot_req ? 1'b1 : cmd_binary),
        .start_boot (boot_req),
        .strobe     (frame_strobe),
        .frame      (frame_data),
        .busy       (reader_busy),
        .done       (pk_done),
        .done_boot  (pk_done_boot),
        .word       (pk_word)
    );

    tape_buffer_ctl #(
        .WORD_W (WORD_W)
    ) u_bufctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_start  (ext_start),
        .start_auto (cmd_auto),
        .take       (buf_take),
        .ret        (reader_return),
        .done       (pk_done),
        .done_boot  (pk_done_boot),
        .word       (pk_word),
        .buf_word   (buffer_word),
        .ready      (word_ready),
        .io_word    (io_word)
    );

    tape_boot_seq #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .OP_W   (OP_W)
    ) u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (boot_go),
        .rd_busy   (reader_busy),
        .done      (pk_done),
        .done_boot (pk_done_boot),
        .word      (pk_word),
        .req       (boot_req),
        .active    (boot_active),
        .we        (mem_we),
        .waddr     (mem_addr),
        .wdata     (mem_wdata),
        .jump      (jump_valid),
        .jaddr     (jump_addr),
        .error     (boot_error)
    );
endmodule

// File: rtl/tape_word_assembler_chk.sv
module tape_word_assembler_chk #(
    parameter int unsigned WORD_W = tape_asm_pkg::TA_WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_take,
    input logic              reader_return,
    input logic              pk_done,
    input logic              pk_done_boot,
    input logic              word_ready,
    input logic [WORD_W-1:0] io_word,
    input logic              boot_active,
    input logic              mem_we,
    input logic              jump_valid,
    input logic              boot_error
);
    // R4: ready rises only after an external completion
    p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_ready) |-> $past(pk_done && !pk_done_boot));

    // R4: ready falls only after a take or return pulse
    p_ready_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(word_ready) |-> $past(buf_take || reader_return));

    // R5 / R11: I/O register changes only on a take or an external completion
    p_io_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_word != $past(io_word)) |-> $past(buf_take || (pk_done && !pk_done_boot)));

    // R8: memory writes come only from a running loader
    p_write_in_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(boot_active));

    // R9: a jump pulse leaves the loader stopped
    p_jump_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |-> !boot_active);

    // R10: an error stop makes no write
    p_error_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_error) |-> (!mem_we && !boot_active));

    // R11: ready never rises on a loader word
    p_boot_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_ready) |-> !$past(pk_done_boot));
endmodule

bind tape_word_assembler tape_word_assembler_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .buf_take      (buf_take),
    .reader_return (reader_return),
    .pk_done       (pk_done),
    .pk_done_boot  (pk_done_boot),
    .word_ready    (word_ready),
    .io_word       (io_word),
    .boot_active   (boot_active),
    .mem_we        (mem_we),
    .jump_valid    (jump_valid),
    .boot_error    (boot_error)
);

// File: tb/tape_word_assembler_tb.sv
module tape_word_assembler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_strobe;
    logic [7:0]  frame_data;
    logic        cmd_valid, cmd_binary, cmd_auto;
    logic        buf_take, reader_return, boot_start;
    logic        reader_busy, word_ready, boot_active;
    logic [17:0] buffer_word, io_word, mem_wdata;
    logic        mem_we, jump_valid, boot_error;
    logic [11:0] mem_addr, jump_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          wr_cnt = 0;
    logic [11:0] wr_addr [4];
    logic [17:0] wr_data [4];
    int          jmp_cnt = 0;
    logic [11:0] jmp_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_word_assembler u_dut (
        .clk (clk), .rst_n (rst_n),
        .frame_strobe (frame_strobe), .frame_data (frame_data),
        .cmd_valid (cmd_valid), .cmd_binary (cmd_binary), .cmd_auto (cmd_auto),
        .buf_take (buf_take), .reader_return (reader_return), .boot_start (boot_start),
        .reader_busy (reader_busy), .word_ready (word_ready),
        .buffer_word (buffer_word), .io_word (io_word),
        .boot_active (boot_active), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .jump_valid (jump_valid), .jump_addr (jump_addr),
        .boot_error (boot_error)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            wr_addr[wr_cnt % 4] = mem_addr;
            wr_data[wr_cnt % 4] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (jump_valid) begin
            jmp_cnt  = jmp_cnt + 1;
            jmp_last = jump_addr;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic command(input logic bin, input logic aut);
        cmd_valid = 1'b1; cmd_binary = bin; cmd_auto = aut;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_binary = 1'b0; cmd_auto = 1'b0;
    endtask

    task automatic raw_strobe(input logic [7:0] f);
        frame_strobe = 1'b1; frame_data = f;
        @(negedge clk);
        frame_strobe = 1'b0; frame_data = '0;
    endtask

    task automatic send_frame(input logic [7:0] f);
        while (!reader_busy) @(negedge clk);
        raw_strobe(f);
    endtask

    task automatic send_word(input logic [17:0] w, input logic noise);
        for (int k = 0; k < 3; k++) begin
            logic [5:0] s;
            s = w[17 - 6*k -: 6];
            if (noise && k == 1) send_frame({2'b01, ~s});
            send_frame({1'b1, noise, s});
        end
    endtask

    task automatic pulse_take();
        buf_take = 1'b1; @(negedge clk); buf_take = 1'b0;
    endtask

    task automatic pulse_return();
        reader_return = 1'b1; @(negedge clk); reader_return = 1'b0;
    endtask

    task automatic pulse_boot();
        boot_start = 1'b1; @(negedge clk); boot_start = 1'b0;
    endtask

    task automatic settle(); @(negedge clk); @(negedge clk); endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [17:0] prev;
        rst_n = 1'b0; frame_strobe = 1'b0; frame_data = '0;
        cmd_valid = 1'b0; cmd_binary = 1'b0; cmd_auto = 1'b0;
        buf_take = 1'b0; reader_return = 1'b0; boot_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4", "reset ready", 32'(word_ready), 0);
        chk("R5", "reset io", 32'(io_word), 0);
        chk("R8", "reset boot", 32'(boot_active), 0);
        chk("R7", "reset busy", 32'(reader_busy), 0);

        // R1, R4, R5: single-frame sweep with auto transfer
        for (int v = 0; v < 16; v++) begin
            logic [7:0] f;
            f = 8'(v * 17) ^ 8'h5a;
            command(1'b0, 1'b1);
            send_frame(f);
            settle();
            chk("R1", "alpha buffer", 32'(buffer_word), 32'(f));
            chk("R5", "auto io", 32'(io_word), 32'(f));
            chk("R4", "ready set", 32'(word_ready), 1);
            pulse_return();
            chk("R4", "ready cleared by return", 32'(word_ready), 0);
        end

        // R2, R3, R5: three-frame sweep, no auto, with skipped and noisy frames
        for (int i = 0; i < 12; i++) begin
            logic [17:0] w;
            w = 18'(i * 43691 + 7);
            prev = io_word;
            command(1'b1, 1'b0);
            send_word(w, i[0]);
            settle();
            chk("R2", "binary buffer", 32'(buffer_word), 32'(w));
            chk("R5", "io untouched without auto", 32'(io_word), 32'(prev));
            pulse_take();
            chk("R5", "take copies buffer", 32'(io_word), 32'(w));
            chk("R4", "ready cleared by take", 32'(word_ready), 0);
        end

        // R7: idle strobe ignored; command during a read ignored
        prev = buffer_word;
        raw_strobe(8'hff);
        settle();
        chk("R7", "idle strobe ready", 32'(word_ready), 0);
        chk("R7", "idle strobe buffer", 32'(buffer_word), 32'(prev));
        command(1'b1, 1'b0);
        send_frame(8'h80 | 8'h2a);
        command(1'b0, 1'b1);
        send_frame(8'h33);
        send_frame(8'h80 | 8'h15);
        send_frame(8'h80 | 8'h3c);
        settle();
        chk("R7", "busy command ignored", 32'(buffer_word), 32'({6'h2a, 6'h15, 6'h3c}));
        chk("R7", "io kept", 32'(io_word), 32'(prev));
        pulse_take();

        // R6: completion and take in the same cycle
        command(1'b0, 1'b0);
        send_frame(8'h9c);
        settle();
        pulse_take();
        chk("R6", "setup io", 32'(io_word), 32'h9c);
        command(1'b0, 1'b0);
        send_frame(8'h47);
        pulse_take();
        settle();
        chk("R6", "io gets old word", 32'(io_word), 32'h9c);
        chk("R6", "buffer gets new word", 32'(buffer_word), 32'h47);
        chk("R6", "ready stays set", 32'(word_ready), 1);
        pulse_take();

        // R8, R9, R11: loader run with two deposits and a jump
        prev = buffer_word;
        pulse_boot();
        chk("R8", "loader active", 32'(boot_active), 1);
        command(1'b0, 1'b1);
        send_word({5'b01101, 1'b0, 12'o0100}, 1'b0);
        send_word(18'o123456, 1'b1);
        send_word({5'b01101, 1'b1, 12'o7777}, 1'b0);
        send_word(18'o765432, 1'b0);
        send_word({5'b11000, 1'b0, 12'o0200}, 1'b0);
        settle();
        chk("R8", "write count", 32'(wr_cnt), 2);
        chk("R8", "first addr", 32'(wr_addr[0]), 32'(12'o0100));
        chk("R8", "first data", 32'(wr_data[0]), 32'(18'o123456));
        chk("R8", "second addr", 32'(wr_addr[1]), 32'(12'o7777));
        chk("R8", "second data", 32'(wr_data[1]), 32'(18'o765432));
        chk("R9", "jump count", 32'(jmp_cnt), 1);
        chk("R9", "jump addr", 32'(jmp_last), 32'(12'o0200));
        chk("R9", "loader stopped", 32'(boot_active), 0);
        chk("R10", "no error", 32'(boot_error), 0);
        chk("R11", "ready untouched", 32'(word_ready), 0);
        chk("R11", "buffer untouched", 32'(buffer_word), 32'(prev));
        chk("R11", "reader idle", 32'(reader_busy), 0);

        // R10: unknown opcode stops the loader
        pulse_boot();
        send_word({5'b10000, 1'b0, 12'o0055}, 1'b0);
        settle();
        chk("R10", "error set", 32'(boot_error), 1);
        chk("R10", "loader stopped", 32'(boot_active), 0);
        chk("R10", "no write", 32'(wr_cnt), 2);
        chk("R10", "no jump", 32'(jmp_cnt), 1);
        pulse_boot();
        chk("R10", "error cleared on restart", 32'(boot_error), 0);
        send_word({5'b11000, 1'b1, 12'o0001}, 1'b0);
        settle();
        chk("R9", "second jump addr", 32'(jmp_last), 32'(12'o0001));
        chk("R9", "loader stopped again", 32'(boot_active), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule